// File: doc/BRIEF.md
# I2C Target Front End with High-Speed Mode Tracking

This block is the bus-facing half of an I2C target. It oversamples the SCL and SDA lines with a fast system clock, finds START, repeated START and STOP conditions, and follows the byte and acknowledge framing of the bus. Bytes written by a controller are handed out one at a time on a parallel port. Bytes to be read are taken from a parallel input at the moment the target needs them.

Besides its own 7-bit address, the block recognises the high-speed entry code: a first byte of the form 0000_1xxx sent while the bus is in Fast/Standard mode. No target acknowledges that code. After its ninth clock the block raises `hs_mode`, and the flag stays up across any number of repeated STARTs until a STOP. Downstream timing logic uses `hs_mode` to select the spike-filter and edge-rate settings for the faster bus. The output `sda_oe` asks the pad to pull SDA low. The pad itself, any filtering and any storage behind the byte ports lie outside the block.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset, `sda_oe`, `hs_mode`, `wr_valid` and `rd_take` are 0. SDA falling while SCL is high (START) starts address reception from any state. SDA rising while SCL is high (STOP) returns the block to idle.
- R2: A byte matching 0000_1xxx (the three low bits are ignored) is a master code when it is the first byte after a START while `hs_mode` is 0. It is never acknowledged: `sda_oe` stays 0 through its ninth clock.
- R3: `hs_mode` becomes 1 on the SCL falling edge that ends the ninth clock of a master code.
- R4: While `hs_mode` is 1, repeated STARTs and the address bytes after them leave it at 1. A 0000_1xxx byte is then treated as an ordinary address.
- R5: A STOP clears `hs_mode` to 0.
- R6: An address byte whose upper seven bits equal `TARGET_ADDR` is acknowledged. `sda_oe` is 1 from the SCL fall that ends its 8th bit until the fall that ends its 9th. Bit 0 of that byte selects the direction: 1 is a read and 0 is a write.
- R7: After an address that does not match, the block does not drive SDA and produces no byte output until the next START.
- R8: In a write, each data byte is received MSB first. At the SCL fall after its 8th bit, `wr_valid` pulses for one cycle with the byte on `wr_data`, and the byte is acknowledged.
- R9: In a read, `rd_data` is latched at the SCL fall that ends the address acknowledge and at the fall that ends each controller ACK. `rd_take` pulses in that same cycle. The byte is driven MSB first with `sda_oe` equal to the inverted bit, and `sda_oe` changes only on SCL falls.
- R10: After the controller NACKs a read byte, the block releases SDA and drives nothing until a START or STOP.
- R11: Every output responds `SYNC_STAGES`+1 clock cycles after the pin change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| rd_data | input | 8 | Byte to send on the next read byte |
| sda_oe | output | 1 | 1 pulls SDA low |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte, valid with `wr_valid` |
| rd_take | output | 1 | One-cycle strobe: `rd_data` was latched |

## Verification
The pin change that causes any output effect passes through `SYNC_STAGES` synchroniser flops and one state register, so `sda_oe`, `hs_mode`, `wr_valid`, `wr_data` and `rd_take` are due exactly `SYNC_STAGES`+1 clocks later. The bench records the expected value of every output at the moment it drives each pin change, delays that record by the same number of clocks in a queue, and compares it with the outputs at every falling clock edge. Acknowledge windows, the master-code NACK, the `hs_mode` rise and fall, and each data bit are therefore checked in the exact cycle they are due.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

   localparam int BYTE_W = 8;
   localparam logic [4:0] HS_CODE_PREFIX = 5'b00001;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_WRITE,
      ST_READ,
      ST_RACK,
      ST_WAIT
   } tgt_state_t;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;

   function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
      return b[BYTE_W-1:3] == HS_CODE_PREFIX;
   endfunction

endpackage

// File: rtl/i2c_hs_sync.sv
module i2c_hs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] ff;

   initial assert (STAGES >= 2) else $error("i2c_hs_sync: STAGES must be at least 2");

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff[0] <= RST_VAL;
               else        ff[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff[s] <= RST_VAL;
               else        ff[s] <= ff[s-1];
            end
         end
      end
   endgenerate

   assign q = ff[STAGES-1];

endmodule

// File: rtl/i2c_hs_events.sv
module i2c_hs_events
   import i2c_hs_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_pin,
   input  logic    sda_pin,
   output bus_ev_t ev
);

   logic scl_s, sda_s, scl_d, sda_d;

   i2c_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_pin), .q(scl_s)
   );

   i2c_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_pin), .q(sda_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_comb begin
      ev.scl      = scl_s;
      ev.sda      = sda_s;
      ev.scl_rise = scl_s & ~scl_d;
      ev.scl_fall = ~scl_s & scl_d;
      ev.start    = scl_s & scl_d & sda_d & ~sda_s;
      ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
   end

   // R1: a bus condition needs SCL high on both of the samples it compares
   p_cond_scl_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.start || ev.stop) |-> (scl_s && $past(scl_s)));

endmodule

// File: rtl/i2c_hs_shifter.sv
module i2c_hs_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         sample,
   input  logic         sample_bit,
   input  logic         load,
   input  logic [W-2:0] load_val,
   input  logic         advance,
   output logic [W-1:0] rx,
   output logic         tx_next,
   output logic         full
);

   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic [W-2:0]  tx;

   initial assert (W >= 3) else $error("i2c_hs_shifter: W must be at least 3");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         rx  <= '0;
         tx  <= '0;
      end else begin
         if (load || clear) cnt <= '0;
         else if (sample)   cnt <= cnt + CW'(1);
         if (sample) rx <= {rx[W-2:0], sample_bit};
         if (load)         tx <= load_val;
         else if (advance) tx <= {tx[W-3:0], 1'b0};
      end
   end

   assign tx_next = tx[W-2];
   assign full    = (cnt == CW'(W));

   // R8: the bit count never runs past one byte
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(W));

endmodule

// File: rtl/i2c_hs_mode_track.sv
module i2c_hs_mode_track (
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   input  logic code_done,
   output logic hs
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hs <= 1'b0;
      else if (stop)      hs <= 1'b0;
      else if (code_done) hs <= 1'b1;
   end

   // R5: STOP always ends high-speed mode
   p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !hs);

   // R3: high-speed mode starts only from a finished master code
   p_hs_from_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs) |-> $past(code_done));

endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
   import i2c_hs_pkg::*;
#(
   parameter logic [6:0] TARGET_ADDR = 7'h50,
   parameter int         SYNC_STAGES = 2,
   parameter bit         HS_ENABLE   = 1'b1,
   parameter int         CLK_HZ      = 50_000_000,
   parameter int         HS_SCL_HZ   = 3_400_000,
   parameter int         MIN_OSR     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              hs_mode,
   output logic              wr_valid,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_take
);

   localparam int OSR = CLK_HZ / HS_SCL_HZ;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("i2c_hs_target: SYNC_STAGES below 2");
      assert (OSR >= MIN_OSR) else $error("i2c_hs_target: clock too slow for high-speed SCL");
      assert (TARGET_ADDR[6:2] != HS_CODE_PREFIX) else $error("i2c_hs_target: address collides with master code");
   end

   bus_ev_t           ev;
   tgt_state_t        state;
   logic              is_code, rw, mack;
   logic              oe_q, wv_q, rt_q;
   logic [BYTE_W-1:0] wd_q;
   logic [BYTE_W-1:0] rx;
   logic              tx_next, full;
   logic              sh_sample, sh_clear, sh_adv, load_rd;
   logic              code_done, hs;

   i2c_hs_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
      .clk(clk), .rst_n(rst_n), .scl_pin(scl_i), .sda_pin(sda_i), .ev(ev)
   );

   always_comb begin
      sh_sample = ev.scl_rise &&
                  (state == ST_ADDR || state == ST_WRITE || state == ST_READ);
      sh_clear  = ev.start || (state == ST_ACK && ev.scl_fall);
      load_rd   = !ev.start && !ev.stop && ev.scl_fall &&
                  ((state == ST_ACK && !is_code && rw) || (state == ST_RACK && mack));
      sh_adv    = (state == ST_READ) && ev.scl_fall && !full;
      code_done = (state == ST_ACK) && is_code && ev.scl_fall;
   end

   i2c_hs_shifter #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clear(sh_clear), .sample(sh_sample), .sample_bit(ev.sda),
      .load(load_rd), .load_val(rd_data[BYTE_W-2:0]), .advance(sh_adv),
      .rx(rx), .tx_next(tx_next), .full(full)
   );

   generate
      if (HS_ENABLE) begin : g_hs
         i2c_hs_mode_track u_mode (
            .clk(clk), .rst_n(rst_n), .stop(ev.stop), .code_done(code_done), .hs(hs)
         );
      end else begin : g_no_hs
         assign hs = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_code <= 1'b0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         oe_q    <= 1'b0;
         wv_q    <= 1'b0;
         wd_q    <= '0;
         rt_q    <= 1'b0;
      end else begin
         wv_q <= 1'b0;
         rt_q <= 1'b0;
         if (ev.stop) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
         end else if (ev.start) begin
            state   <= ST_ADDR;
            oe_q    <= 1'b0;
            is_code <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (ev.scl_fall && full) begin
                     if (HS_ENABLE && !hs && is_hs_code(rx)) begin
                        state   <= ST_ACK;
                        is_code <= 1'b1;
                        oe_q    <= 1'b0;
                     end else if (rx[BYTE_W-1:1] == TARGET_ADDR) begin
                        state <= ST_ACK;
                        rw    <= rx[0];
                        oe_q  <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ACK: begin
                  if (ev.scl_fall) begin
                     if (is_code) begin
                        state <= ST_WAIT;
                        oe_q  <= 1'b0;
                     end else if (rw) begin
                        state <= ST_READ;
                        oe_q  <= ~rd_data[BYTE_W-1];
                        rt_q  <= 1'b1;
                     end else begin
                        state <= ST_WRITE;
                        oe_q  <= 1'b0;
                     end
                  end
               end
               ST_WRITE: begin
                  if (ev.scl_fall && full) begin
                     state <= ST_ACK;
                     wv_q  <= 1'b1;
                     wd_q  <= rx;
                     oe_q  <= 1'b1;
                  end
               end
               ST_READ: begin
                  if (ev.scl_fall) begin
                     if (full) begin
                        state <= ST_RACK;
                        oe_q  <= 1'b0;
                     end else begin
                        oe_q <= ~tx_next;
                     end
                  end
               end
               ST_RACK: begin
                  if (ev.scl_rise) mack <= ~ev.sda;
                  if (ev.scl_fall) begin
                     if (mack) begin
                        state <= ST_READ;
                        oe_q  <= ~rd_data[BYTE_W-1];
                        rt_q  <= 1'b1;
                     end else begin
                        state <= ST_WAIT;
                        oe_q  <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = oe_q;
   assign hs_mode  = hs;
   assign wr_valid = wv_q;
   assign wr_data  = wd_q;
   assign rd_take  = rt_q;

   // R2: the master code is never acknowledged
   p_code_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK && is_code) |-> !oe_q);

   // R8: every delivered write byte is acknowledged in the same cycle
   p_write_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wv_q |-> oe_q);

   // R9: the SDA drive moves only while SCL is low
   p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> !ev.scl);

   // R9: read data is taken only at an SCL fall
   p_take_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rt_q |-> $past(ev.scl_fall));

   // R7, R10: idle and waiting states never drive the bus
   p_quiet_states_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_WAIT) |-> !oe_q);

endmodule

// File: tb/i2c_hs_target_test.sv
module i2c_hs_target_test;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;   // R11: pin change to output delay
   localparam int HOLD       = 4;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [7:0] rd_data = 8'h00;
   logic       sda_oe, hs_mode, wr_valid, rd_take;
   logic [7:0] wr_data;
   wire        sda_line = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_hs_target #(.TARGET_ADDR(7'h50), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .rd_data(rd_data), .sda_oe(sda_oe), .hs_mode(hs_mode),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_take(rd_take)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   logic       exp_oe = 1'b0, exp_hs = 1'b0, p_wr = 1'b0, p_rt = 1'b0;
   logic [7:0] p_wd = 8'h00;

   logic       q_oe[$], q_hs[$], q_wv[$], q_rt[$];
   logic [7:0] q_wd[$];
   string      q_rq[$];

   task automatic check(input string rq, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic push_intent();
      q_oe.push_back(exp_oe);
      q_hs.push_back(exp_hs);
      q_wv.push_back(p_wr);
      q_wd.push_back(p_wd);
      q_rt.push_back(p_rt);
      q_rq.push_back(cur_req);
      p_wr = 1'b0;
      p_rt = 1'b0;
   endtask

   // one system clock: compare against intent from LAT cycles ago, then drive pins
   task automatic step(input logic scl_v, input logic sda_v);
      logic e_oe, e_hs, e_wv, e_rt;
      logic [7:0] e_wd;
      string rq;
      @(negedge clk);
      e_oe = q_oe.pop_front();
      e_hs = q_hs.pop_front();
      e_wv = q_wv.pop_front();
      e_wd = q_wd.pop_front();
      e_rt = q_rt.pop_front();
      rq   = q_rq.pop_front();
      check(rq, "sda_oe", {7'b0, sda_oe}, {7'b0, e_oe});
      check(rq, "hs_mode", {7'b0, hs_mode}, {7'b0, e_hs});
      check(rq, "wr_valid", {7'b0, wr_valid}, {7'b0, e_wv});
      check(rq, "rd_take", {7'b0, rd_take}, {7'b0, e_rt});
      if (e_wv) check(rq, "wr_data", wr_data, e_wd);
      scl_m = scl_v;
      sda_m = sda_v;
      push_intent();
   endtask

   task automatic hold(input int n);
      for (int i = 0; i < n; i++) step(scl_m, sda_m);
   endtask

   task automatic start_cond();
      step(1'b0, 1'b1); hold(HOLD);
      step(1'b1, 1'b1); hold(HOLD);
      step(1'b1, 1'b0); hold(HOLD);
      step(1'b0, 1'b0); hold(HOLD);
   endtask

   task automatic stop_cond();
      step(1'b0, 1'b0); hold(HOLD);
      step(1'b1, 1'b0); hold(HOLD);
      exp_hs = 1'b0;                        // R5
      step(1'b1, 1'b1); hold(HOLD);
   endtask

   // controller sends a byte; ack: target should ACK, wr: data byte,
   // code: master code, rd: read data starts after this byte
   task automatic send_byte(input logic [7:0] b, input bit ack, input bit wr,
                            input bit code, input bit rd);
      for (int i = 7; i >= 0; i--) begin
         step(1'b0, b[i]); hold(HOLD);
         step(1'b1, b[i]); hold(HOLD);
         if (i == 0) begin
            exp_oe = ack;
            if (wr) begin p_wr = 1'b1; p_wd = b; end
         end
         step(1'b0, b[i]); hold(HOLD);
      end
      step(1'b0, 1'b1); hold(HOLD);
      step(1'b1, 1'b1); hold(HOLD);
      exp_oe = rd ? ~rd_data[7] : 1'b0;
      p_rt   = rd;
      if (code) exp_hs = 1'b1;              // R3
      step(1'b0, 1'b1); hold(HOLD);
   endtask

   // target sends exp_b; controller answers mack; nxt is the following byte
   task automatic recv_byte(input logic [7:0] exp_b, input bit mack,
                            input logic [7:0] nxt);
      rd_data = nxt;
      for (int i = 7; i >= 0; i--) begin
         step(1'b0, 1'b1); hold(HOLD);
         step(1'b1, 1'b1); hold(HOLD);
         exp_oe = (i > 0) ? ~exp_b[i-1] : 1'b0;
         step(1'b0, 1'b1); hold(HOLD);
      end
      step(1'b0, ~mack); hold(HOLD);
      step(1'b1, ~mack); hold(HOLD);
      exp_oe = mack ? ~nxt[7] : 1'b0;
      p_rt   = mack;
      step(1'b0, ~mack); hold(HOLD);
      step(1'b0, 1'b1); hold(HOLD);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < LAT; i++) push_intent();

      // R1: reset state
      cur_req = "R1";
      hold(6);
      rst_n = 1'b1;
      hold(8);

      // R6/R8: Fast/Standard write of two bytes
      cur_req = "R6";
      start_cond();
      send_byte(8'hA0, 1, 0, 0, 0);
      cur_req = "R8";
      send_byte(8'hA5, 1, 1, 0, 0);
      send_byte(8'h3C, 1, 1, 0, 0);
      cur_req = "R1";
      stop_cond();

      // R7: other address, following byte ignored
      cur_req = "R7";
      start_cond();
      send_byte(8'h42, 0, 0, 0, 0);
      send_byte(8'hFF, 0, 0, 0, 0);
      send_byte(8'h00, 0, 0, 0, 0);
      stop_cond();

      // R9/R10: single-byte read, NACK, then ignored clocks
      cur_req = "R9";
      rd_data = 8'h96;
      start_cond();
      send_byte(8'hA1, 1, 0, 0, 1);
      recv_byte(8'h96, 0, 8'h00);
      cur_req = "R10";
      send_byte(8'h00, 0, 0, 0, 0);
      stop_cond();

      // R2/R3: master code entry
      cur_req = "R2";
      start_cond();
      cur_req = "R3";
      send_byte(8'h0D, 0, 0, 1, 0);
      // R4: high-speed write after repeated START
      cur_req = "R4";
      start_cond();
      send_byte(8'hA0, 1, 0, 0, 0);
      cur_req = "R8";
      send_byte(8'h81, 1, 1, 0, 0);
      // R9: multi-byte read in high-speed mode
      cur_req = "R9";
      rd_data = 8'hC3;
      start_cond();
      send_byte(8'hA1, 1, 0, 0, 1);
      recv_byte(8'hC3, 1, 8'h5A);
      recv_byte(8'h5A, 0, 8'h00);
      // R4: master-code pattern inside high-speed mode is just an address
      cur_req = "R4";
      start_cond();
      send_byte(8'h09, 0, 0, 0, 0);
      cur_req = "R5";
      stop_cond();

      // R2: other low bits of the code, then write and STOP
      cur_req = "R2";
      start_cond();
      send_byte(8'h0F, 0, 0, 1, 0);
      cur_req = "R4";
      start_cond();
      send_byte(8'hA0, 1, 0, 0, 0);
      send_byte(8'h00, 1, 1, 0, 0);
      cur_req = "R5";
      stop_cond();
      cur_req = "R11";
      hold(10);

      summary();
      $finish;
   end

endmodule